// File: doc/BRIEF.md
# Isochronous Source-Packet FIFO Port

This block is a byte-wide streaming port between an external device and an internal packet FIFO. Data moves in fixed-size source packets whose length is a parameter. The FIFO holds a whole number of such packets. Everything runs on the port clock, so if that clock stops, all transfer stops with it.

One direction input picks the mode. At 0 the port transmits: bytes on the shared 8-bit bus are captured into the FIFO on each rising edge while the enable strobe is high. The internal link side may start draining only once a complete packet is stored. At 1 the port receives: the link side fills the FIFO, and the enable strobe puts the head byte onto the bus. Each new byte appears after a falling clock edge. Any change of the direction input flushes the FIFO.

An access-permit output tells the external device when to act. In transmit it is high while there is room for another whole packet. In receive it rises once a complete packet is waiting. It falls either on the first byte read or after the last byte of the packet, as chosen by a mode input.

Top module: `isoPacketPort`

## Requirements
- R1: After reset, the port is in receive mode with an empty FIFO. accessOk and linkPktAvail are low, and the bus is not driven.
- R2: In any cycle where dirRx differs from the mode in force, the FIFO is emptied, and no byte is stored or removed in that cycle. The packet count starts again from zero in the new mode.
- R3: In transmit (dirRx=0), each rising edge with enStrobe high and the FIFO not full stores the bus byte. The link side receives the bytes in the same order on linkRdData, one per rising edge with linkRdEn high.
- R4: In transmit, accessOk is high exactly when the free space is at least one full packet (PKT_BYTES bytes).
- R5: In transmit, linkPktAvail is high, and linkRdEn removes a byte, only when a full packet is stored or a packet already started is not yet finished. Otherwise linkRdEn is ignored.
- R6: The port drives busData only while in receive mode with enStrobe high. At all other times the bus is left free, and an external driver's value is seen unchanged.
- R7: In receive, while enStrobe is high, the FIFO head byte is on the bus from the falling edge onward. A rising edge with enStrobe high and the FIFO not empty removes that byte, and the next byte shows after the following falling edge.
- R8: In receive, accessOk rises once a full packet of PKT_BYTES bytes is held, counting from the start of the packet being read.
- R9: In receive with relMode=0, accessOk is high only at a packet boundary with a full packet held. It falls after the first byte of the packet is read.
- R10: In receive with relMode=1, accessOk stays high through the packet. It falls after the last byte is read unless another full packet is already held.
- R11: A store into a full FIFO is dropped (bus byte in transmit, linkWrEn in receive). A read strobe on an empty FIFO in receive removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all state moves on it |
| rstN | input | 1 | Asynchronous active-low reset |
| dirRx | input | 1 | Direction: 0 transmit, 1 receive; any change flushes |
| relMode | input | 1 | Receive permit release: 0 on first byte, 1 after last byte |
| enStrobe | input | 1 | Data strobe: capture in transmit, bus output in receive |
| busData | inout | 8 | Shared byte bus to the external device |
| accessOk | output | 1 | Access-permit handshake to the external device |
| linkWrEn | input | 1 | Link side stores a byte (receive) |
| linkWrData | input | 8 | Byte stored by the link side |
| linkRdEn | input | 1 | Link side takes a byte (transmit) |
| linkRdData | output | 8 | FIFO head byte for the link side |
| linkPktAvail | output | 1 | A packet may be drained by the link side (transmit) |

## Verification
In transmit, an external capture and a link-side removal can land on the same rising edge, and so can a link-side store and a bus read in receive. Either way the FIFO count and the packet-boundary tracking must stay consistent. The bench sets both strobes high together, for several cycles, partly through a packet and with the FIFO near full. A scoreboard queue of expected bytes then judges the byte order, and the expected accessOk and linkPktAvail are recomputed every cycle from the requirements.

// File: rtl/isoPortPkg.sv
package isoPortPkg;
  localparam int BYTE_W = 8;

  // Strobes from the control to the datapath for one clock cycle
  typedef struct packed {
    logic flush;    // empty the FIFO this cycle
    logic push;     // store one byte
    logic pop;      // remove the head byte
    logic fromBus;  // store source: bus (transmit) or link (receive)
  } fifoCtrlT;
endpackage

// File: rtl/isoFifoPath.sv
module isoFifoPath
  import isoPortPkg::*;
#(
  parameter int PKT_BYTES = 188,
  parameter int PKT_SLOTS = 2,
  localparam int DEPTH = PKT_BYTES * PKT_SLOTS,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtrlT          ctrl,
  input  logic [BYTE_W-1:0] busIn,
  input  logic [BYTE_W-1:0] linkWrData,
  output logic [BYTE_W-1:0] headData,
  output logic [BYTE_W-1:0] busOutQ,
  output logic [CW-1:0]     count
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [BYTE_W-1:0] wrByte;

  assign wrByte   = ctrl.fromBus ? busIn : linkWrData;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (ctrl.push) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (ctrl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctrl.push) wrPtr <= (wrPtr == LAST_ADDR) ? '0 : wrPtr + 1'b1;
      if (ctrl.pop)  rdPtr <= (rdPtr == LAST_ADDR) ? '0 : rdPtr + 1'b1;
      case ({ctrl.push, ctrl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Receive output byte moves on the falling edge of the port clock
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) busOutQ <= '0;
    else       busOutQ <= headData;
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.push |-> (count < DEPTH_C));
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pop |-> (count != '0));
  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flush |=> (count == '0));
endmodule

// File: rtl/isoPortCtrl.sv
module isoPortCtrl
  import isoPortPkg::*;
#(
  parameter int PKT_BYTES = 188,   // at least 2
  parameter int PKT_SLOTS = 2,
  localparam int DEPTH = PKT_BYTES * PKT_SLOTS,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(PKT_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirRx,
  input  logic          relMode,
  input  logic          enStrobe,
  input  logic          linkRdEn,
  input  logic          linkWrEn,
  input  logic [CW-1:0] count,
  output fifoCtrlT      ctrl,
  output logic          rxActive,
  output logic          accessOk,
  output logic          linkPktAvail
);
  localparam logic [CW:0] PKT_W      = (CW+1)'(PKT_BYTES);
  localparam logic [CW:0] DEPTH_W    = (CW+1)'(DEPTH);
  localparam logic [CW:0] ROOM_LIMIT = (CW+1)'(DEPTH - PKT_BYTES);
  localparam logic [IW-1:0] LAST_IDX = IW'(PKT_BYTES - 1);

  logic dirQ;
  logic [IW-1:0] rdIdx;
  logic [CW:0] countW, fillW;
  logic flush, pktReady, startedPkt, notFull, notEmpty;

  assign countW     = {1'b0, count};
  assign fillW      = countW + (CW+1)'(rdIdx);
  assign pktReady   = countW >= PKT_W;
  assign startedPkt = rdIdx != '0;
  assign notFull    = countW < DEPTH_W;
  assign notEmpty   = count != '0;
  assign flush      = dirRx != dirQ;
  assign rxActive   = dirQ;

  assign linkPktAvail = !dirQ && (startedPkt || pktReady);

  always_comb begin
    ctrl.flush   = flush;
    ctrl.fromBus = !dirQ;
    ctrl.push    = !flush && notFull && (dirQ ? linkWrEn : enStrobe);
    ctrl.pop     = !flush && (dirQ ? (enStrobe && notEmpty)
                                   : (linkRdEn && linkPktAvail));
  end

  always_comb begin
    if (!dirQ)        accessOk = countW <= ROOM_LIMIT;
    else if (relMode) accessOk = fillW >= PKT_W;
    else              accessOk = !startedPkt && pktReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= 1'b1;
      rdIdx <= '0;
    end else begin
      dirQ <= dirRx;
      if (flush)         rdIdx <= '0;
      else if (ctrl.pop) rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
    end
  end

  // R9
  first_read_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirQ && !relMode && ctrl.pop && !startedPkt) |=> (!accessOk || relMode));
  // R10
  mid_packet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirQ && relMode && accessOk && ctrl.pop && rdIdx != LAST_IDX)
      |=> (accessOk || !relMode));
  // R5
  no_early_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dirQ && !startedPkt && !pktReady) |-> !ctrl.pop);
endmodule

// File: rtl/isoPacketPort.sv
module isoPacketPort
  import isoPortPkg::*;
#(
  parameter int PKT_BYTES = 188,
  parameter int PKT_SLOTS = 2,
  localparam int DEPTH = PKT_BYTES * PKT_SLOTS,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRx,
  input  logic              relMode,
  input  logic              enStrobe,
  inout  wire  [BYTE_W-1:0] busData,
  output logic              accessOk,
  input  logic              linkWrEn,
  input  logic [BYTE_W-1:0] linkWrData,
  input  logic              linkRdEn,
  output logic [BYTE_W-1:0] linkRdData,
  output logic              linkPktAvail
);
  fifoCtrlT ctrl;
  logic rxActive;
  logic [CW-1:0] count;
  logic [BYTE_W-1:0] headData, busOutQ;

  isoPortCtrl #(.PKT_BYTES(PKT_BYTES), .PKT_SLOTS(PKT_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .relMode(relMode),
    .enStrobe(enStrobe), .linkRdEn(linkRdEn), .linkWrEn(linkWrEn),
    .count(count), .ctrl(ctrl), .rxActive(rxActive),
    .accessOk(accessOk), .linkPktAvail(linkPktAvail)
  );

  isoFifoPath #(.PKT_BYTES(PKT_BYTES), .PKT_SLOTS(PKT_SLOTS)) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busIn(busData),
    .linkWrData(linkWrData), .headData(headData), .busOutQ(busOutQ),
    .count(count)
  );

  // R6: bus driven only in receive with the strobe high
  assign busData    = (rxActive && enStrobe) ? busOutQ : {BYTE_W{1'bz}};
  assign linkRdData = headData;
endmodule

// File: tb/isoPacketPort_tb.sv
module isoPacketPort_tb;
  localparam int P = 4;
  localparam int S = 2;
  localparam int D = P * S;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirRx = 1'b1, relMode = 1'b0, enStrobe = 1'b0;
  logic linkWrEn = 1'b0, linkRdEn = 1'b0;
  logic [7:0] linkWrData = '0, tbDrv = 8'hA5;
  logic [7:0] linkRdData;
  logic accessOk, linkPktAvail, tbOe;
  wire  [7:0] busData;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign tbOe = !(dirRx && enStrobe);
  assign busData = tbOe ? tbDrv : 8'bz;

  isoPacketPort #(.PKT_BYTES(P), .PKT_SLOTS(S)) u_dut (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .relMode(relMode),
    .enStrobe(enStrobe), .busData(busData), .accessOk(accessOk),
    .linkWrEn(linkWrEn), .linkWrData(linkWrData), .linkRdEn(linkRdEn),
    .linkRdData(linkRdData), .linkPktAvail(linkPktAvail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Scoreboard state: expected bytes and the requirement-level model
  logic [7:0] expQ[$];
  bit mDir = 1'b1;
  int cnt = 0, idx = 0;

  // Monitor: samples after the falling edge, away from the rising edge
  always begin
    @(negedge clk);
    #1;
    if (!rstN) begin
      mDir = 1'b1; cnt = 0; idx = 0; expQ.delete();
    end else if (!done) begin
      bit expOk, expAvail, pushNow, popNow;
      expAvail = !mDir && (idx != 0 || cnt >= P);
      if (!mDir)        expOk = (D - cnt) >= P;
      else if (relMode) expOk = (cnt + idx) >= P;
      else              expOk = (idx == 0) && (cnt >= P);
      check(accessOk == expOk, mDir ? (relMode ? "R8/R10" : "R8/R9") : "R4",
            accessOk, expOk);
      check(linkPktAvail == expAvail, "R5", linkPktAvail, expAvail);
      if (tbOe && !(mDir && enStrobe))
        check(busData == tbDrv, "R6", busData, tbDrv);
      if (dirRx != mDir) begin
        // R2: direction change empties everything, no transfer this cycle
        mDir = dirRx; cnt = 0; idx = 0; expQ.delete();
      end else begin
        popNow  = mDir ? (enStrobe && cnt != 0) : (linkRdEn && expAvail);
        pushNow = (cnt < D) && (mDir ? linkWrEn : enStrobe);
        if (popNow) begin
          logic [7:0] e;
          logic [7:0] a;
          e = (expQ.size() != 0) ? expQ.pop_front() : 8'h00;
          a = mDir ? busData : linkRdData;
          check(a == e, mDir ? "R7/R11" : "R3/R11", a, e);
          idx = (idx == P - 1) ? 0 : idx + 1;
        end
        if (pushNow) expQ.push_back(mDir ? linkWrData : tbDrv);
        cnt = cnt + int'(pushNow) - int'(popNow);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(accessOk == 1'b0, "R1", accessOk, 0);
    check(linkPktAvail == 1'b0, "R1", linkPktAvail, 0);
    check(busData == tbDrv, "R1", busData, tbDrv);
    tick();

    // Transmit: fill past full, with an early drain attempt (R5, R11)
    dirRx = 1'b0; tick();
    for (int i = 0; i < 10; i++) begin
      enStrobe = 1'b1; tbDrv = 8'h10 + 8'(i); linkRdEn = (i == 1);
      tick();
    end
    enStrobe = 1'b0; linkRdEn = 1'b1;
    repeat (3) tick();
    // Capture and drain on the same edge (R3, R4)
    enStrobe = 1'b1;
    for (int i = 0; i < 3; i++) begin tbDrv = 8'h40 + 8'(i); tick(); end
    enStrobe = 1'b0;
    repeat (9) tick();
    linkRdEn = 1'b0;

    // Partial data then direction change flushes (R2)
    enStrobe = 1'b1;
    for (int i = 0; i < 3; i++) begin tbDrv = 8'h60 + 8'(i); tick(); end
    enStrobe = 1'b0; dirRx = 1'b1; tick();
    @(negedge clk); #1;
    check(accessOk == 1'b0, "R2", accessOk, 0);
    tick();

    // Receive, release on first byte (R7, R8, R9, R11)
    relMode = 1'b0;
    for (int i = 0; i < 6; i++) begin
      linkWrEn = 1'b1; linkWrData = 8'h80 + 8'(i); tick();
    end
    linkWrEn = 1'b0; tick();
    enStrobe = 1'b1;
    repeat (8) tick();
    enStrobe = 1'b0; tick();

    // Receive, release after last byte, with stores during reads (R10, R11)
    relMode = 1'b1;
    for (int i = 0; i < 9; i++) begin
      linkWrEn = 1'b1; linkWrData = 8'hB0 + 8'(i); tick();
    end
    linkWrEn = 1'b0;
    enStrobe = 1'b1;
    for (int i = 0; i < 12; i++) begin
      linkWrEn = (i >= 2 && i < 5); linkWrData = 8'hD0 + 8'(i); tick();
    end
    linkWrEn = 1'b0; enStrobe = 1'b0; tick();

    // Data in receive, toggle away and back: old bytes gone (R2)
    for (int i = 0; i < 3; i++) begin
      linkWrEn = 1'b1; linkWrData = 8'hE0 + 8'(i); tick();
    end
    linkWrEn = 1'b0; dirRx = 1'b0; tick();
    dirRx = 1'b1; tick();
    linkWrEn = 1'b1; linkWrData = 8'hF0; tick();
    linkWrEn = 1'b0;
    @(negedge clk); #1;
    check(accessOk == 1'b0, "R2", accessOk, 0);
    tick();
    repeat (2) tick();
    finish();
  end
endmodule